// File: doc/BRIEF.md
# Sample-Rate Ratio Tracker for an Asynchronous Resampler

This block estimates how fast an incoming audio sample stream runs compared with a fixed output sample rate. The output rate is derived from a fast system clock; the input rate is not known in advance and may drift. The system clock runs much faster than any audio rate and does not have to be an integer multiple of the 44.1 kHz or 48 kHz families. The block sees two single-cycle pulses on the system clock: a strobe for each arriving input sample and a tick for each output sample to be produced.

A second-order digital loop keeps a signed phase error in units of input samples. Each input strobe adds one sample to it, and each output tick removes the current ratio estimate. On every input strobe a proportional-integral filter with shift-based gains corrects the ratio. The ratio is reported as an unsigned Q8.24 number equal to the input rate divided by the output rate. While acquiring, the filter uses wide gains. After a run of small errors it moves to much narrower tracking gains and raises a lock flag. With narrow gains the loop corner sits far below the strobe rate, so timing jitter on the strobes barely reaches the ratio.

On every output tick the block also advances a 24-bit fractional position by the ratio. It reports that fraction and the count of whole input samples stepped over. A downstream polyphase resampler uses the fraction to choose its coefficient phase and the step to move its input pointer.

Top module: `asrc_ratio_dpll`

## Requirements
- R1: During and right after reset, `ratio_q` equals the initial value 0x01000000 (1.0 in Q8.24), `phase_frac` is 0, and `phase_valid` and `locked` are 0.
- R2: With input strobes jittered by up to ±3 clock cycles around a mean period of 16·320/147 cycles, and output ticks every 16 cycles, `ratio_q` settles to within 2 % of 147/320 in Q8.24 (bits 31:24 integer, bits 23:0 fraction), and `locked` is 1.
- R3: When the strobe period changes to exactly 32 cycles, `ratio_q` settles to within 2 % of 0x00800000, and `locked` is 1.
- R4: `locked` rises only after LOCK_N consecutive strobes whose phase error magnitude is at most LOCK_TH. Fewer than LOCK_N strobes after a restart leave it at 0. While locked, the tracking gains are used.
- R5: During a slow linear ramp of the strobe period (5 % over 800 strobes), `locked` stays 1, and at the end `ratio_q` is within 2 % of the true ratio.
- R6: One cycle after each `out_tick`, `phase_valid` is 1 and {`phase_step`,`phase_frac`} equals {9'b0, previous `phase_frac`} plus {1'b0, `ratio_q` as seen at the tick}. The 24-bit fraction therefore advances monotonically modulo one input sample.
- R7: In every cycle not preceded by an `out_tick`, `phase_valid` is 0 and `phase_frac` keeps its value.
- R8: A phase error magnitude above UNLOCK_TH, for example from a burst of extra strobes, clears `locked` and returns the loop to acquisition gains.
- R9: When no strobe arrives for TIMEOUT cycles, `locked` clears.
- R10: `ratio_q` changes only in the cycle after a strobe has been measured. With no strobes, including across a timeout, it holds its value.
- R11: The first strobe after reset or after a timeout only re-aligns the phase error to zero; `ratio_q` is unchanged by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_strobe | input | 1 | One-cycle pulse per arriving input sample, already synchronous to clk |
| out_tick | input | 1 | One-cycle pulse per output sample to produce |
| ratio_q | output | 32 | Smoothed input/output rate ratio, unsigned Q8.24 |
| phase_frac | output | 24 | Fractional input-sample position of the latest output sample |
| phase_step | output | 9 | Whole input samples stepped over at the latest output tick |
| phase_valid | output | 1 | Pulses one cycle after each out_tick, when phase_frac and phase_step are new |
| locked | output | 1 | Loop has settled and runs with tracking gains |

## Verification
The hardest state to reach is a loop that is already locked and then has to hold lock through a change it can follow, while still dropping lock on a change it cannot follow. The stimulus first lets the loop acquire on jittered strobes at a non-integer mean period. It then ramps the period slowly while counting every cycle in which lock is low. Only after that does it inject a burst of extra strobes, and then a silent gap longer than the timeout. Both must break lock. The first strobe after the gap must leave the ratio untouched.

// File: rtl/asrc_pkg.sv
package asrc_pkg;
  localparam int FRAC_W  = 24;
  localparam int INT_W   = 8;
  localparam int RATIO_W = INT_W + FRAC_W;
  localparam int ERR_W   = 40;
  localparam int STEP_W  = INT_W + 1;
  localparam int SUM_W   = STEP_W + FRAC_W;

  typedef logic [RATIO_W-1:0]       ratio_t;
  typedef logic signed [ERR_W-1:0]  err_t;
  typedef logic [FRAC_W-1:0]        frac_t;
  typedef logic [SUM_W-1:0]         nco_sum_t;

  localparam err_t ONE_SAMPLE = err_t'(1 << FRAC_W);

  // Zero-extend a ratio into the signed error domain.
  function automatic err_t f_widen(ratio_t r);
    return $signed({{(ERR_W-RATIO_W){1'b0}}, r});
  endfunction

  // Phase error update: plus one sample per strobe, minus ratio per tick, clamped.
  function automatic err_t f_err_next(err_t acc, logic add_one, logic sub_ratio, ratio_t r);
    logic signed [ERR_W:0] s;
    s = {acc[ERR_W-1], acc};
    if (add_one)   s = s + $signed({1'b0, ONE_SAMPLE});
    if (sub_ratio) s = s - $signed({1'b0, f_widen(r)});
    if (s[ERR_W] != s[ERR_W-1])
      return s[ERR_W] ? {1'b1, {(ERR_W-1){1'b0}}} : {1'b0, {(ERR_W-1){1'b1}}};
    return s[ERR_W-1:0];
  endfunction

  // Clamp a signed value into the unsigned Q8.24 range.
  function automatic ratio_t f_sat_ratio(err_t x);
    if (x[ERR_W-1])               return '0;
    if (|x[ERR_W-2:RATIO_W])      return '1;
    return x[RATIO_W-1:0];
  endfunction

  function automatic logic [ERR_W-1:0] f_mag(err_t x);
    return x[ERR_W-1] ? $unsigned(-x) : $unsigned(x);
  endfunction

  // Output-position step: {whole samples, new fraction}.
  function automatic nco_sum_t f_nco_sum(frac_t ph, ratio_t r);
    return {{STEP_W{1'b0}}, ph} + {1'b0, r};
  endfunction
endpackage

// File: rtl/asrc_phase_det.sv
module asrc_phase_det
  import asrc_pkg::*;
#(
  parameter int TIMEOUT = 65536
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   strobe,
  input  logic   tick,
  input  ratio_t ratio,
  output logic   pd_valid,
  output err_t   pd_err,
  output logic   ev_timeout,
  output logic   starved
);
  localparam int TO_W = $clog2(TIMEOUT + 1);

  logic [TO_W-1:0] idle_cnt;
  err_t            acc, acc_nx;
  logic            idle_hit, measure;

  always_comb begin
    measure  = strobe && !starved;
    idle_hit = !starved && !strobe && (idle_cnt == TO_W'(TIMEOUT - 1));
    if (starved || idle_hit) acc_nx = '0;
    else                     acc_nx = f_err_next(acc, strobe, tick, ratio);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc        <= '0;
      starved    <= 1'b1;
      idle_cnt   <= '0;
      pd_valid   <= 1'b0;
      pd_err     <= '0;
      ev_timeout <= 1'b0;
    end else begin
      acc        <= acc_nx;
      pd_valid   <= measure;
      ev_timeout <= idle_hit;
      if (measure) pd_err <= acc_nx;
      if (strobe)        starved <= 1'b0;
      else if (idle_hit) starved <= 1'b1;
      if (strobe || starved) idle_cnt <= '0;
      else                   idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/asrc_loop_filter.sv
module asrc_loop_filter
  import asrc_pkg::*;
#(
  parameter int          LOCK_N     = 16,
  parameter int unsigned LOCK_TH    = 32'h0100_0000,
  parameter int unsigned UNLOCK_TH  = 32'h0300_0000,
  parameter int          ACQ_KP     = 2,
  parameter int          ACQ_KI     = 6,
  parameter int          TRK_KP     = 7,
  parameter int          TRK_KI     = 12,
  parameter logic [31:0] RATIO_INIT = 32'h0100_0000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pd_valid,
  input  err_t   pd_err,
  input  logic   ev_timeout,
  output ratio_t ratio,
  output logic   locked,
  output logic   err_big
);
  localparam int CNT_W = $clog2(LOCK_N + 1);

  ratio_t           integ, integ_nx, ratio_nx;
  err_t             prop, icorr;
  logic [ERR_W-1:0] mag;
  logic             err_fine;
  logic [CNT_W-1:0] good_cnt;
  int               kp_sh, ki_sh;

  always_comb begin
    kp_sh    = locked ? TRK_KP : ACQ_KP;
    ki_sh    = locked ? TRK_KI : ACQ_KI;
    prop     = pd_err >>> kp_sh;
    icorr    = pd_err >>> ki_sh;
    integ_nx = f_sat_ratio(f_widen(integ) + icorr);
    ratio_nx = f_sat_ratio(f_widen(integ_nx) + prop);
    mag      = f_mag(pd_err);
    err_big  = pd_valid && (mag > ERR_W'(UNLOCK_TH));
    err_fine = mag <= ERR_W'(LOCK_TH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ    <= ratio_t'(RATIO_INIT);
      ratio    <= ratio_t'(RATIO_INIT);
      locked   <= 1'b0;
      good_cnt <= '0;
    end else if (ev_timeout) begin
      locked   <= 1'b0;
      good_cnt <= '0;
    end else if (pd_valid) begin
      integ <= integ_nx;
      ratio <= ratio_nx;
      if (err_big) begin
        locked   <= 1'b0;
        good_cnt <= '0;
      end else if (err_fine) begin
        if (!locked) begin
          if (good_cnt == CNT_W'(LOCK_N - 1)) begin
            locked   <= 1'b1;
            good_cnt <= '0;
          end else begin
            good_cnt <= good_cnt + 1'b1;
          end
        end
      end else begin
        good_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/asrc_phase_nco.sv
module asrc_phase_nco
  import asrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  ratio_t            ratio,
  output frac_t             phase,
  output logic [STEP_W-1:0] step,
  output logic              valid
);
  nco_sum_t sum;

  always_comb sum = f_nco_sum(phase, ratio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      step  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= tick;
      if (tick) begin
        phase <= sum[FRAC_W-1:0];
        step  <= sum[SUM_W-1:FRAC_W];
      end
    end
  end
endmodule

// File: rtl/asrc_ratio_dpll.sv
module asrc_ratio_dpll
  import asrc_pkg::*;
#(
  parameter int          TIMEOUT    = 65536,
  parameter int          LOCK_N     = 16,
  parameter int unsigned LOCK_TH    = 32'h0100_0000,
  parameter int unsigned UNLOCK_TH  = 32'h0300_0000,
  parameter int          ACQ_KP     = 2,
  parameter int          ACQ_KI     = 6,
  parameter int          TRK_KP     = 7,
  parameter int          TRK_KI     = 12,
  parameter logic [31:0] RATIO_INIT = 32'h0100_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_strobe,
  input  logic        out_tick,
  output logic [31:0] ratio_q,
  output logic [23:0] phase_frac,
  output logic [8:0]  phase_step,
  output logic        phase_valid,
  output logic        locked
);
  // Internal events brought out for the checker.
  logic   pd_valid, ev_timeout, starved, err_big;
  err_t   pd_err;
  ratio_t ratio_w;

  asrc_phase_det #(.TIMEOUT(TIMEOUT)) i_det (
    .clk(clk), .rst_n(rst_n), .strobe(in_strobe), .tick(out_tick),
    .ratio(ratio_w), .pd_valid(pd_valid), .pd_err(pd_err),
    .ev_timeout(ev_timeout), .starved(starved)
  );

  asrc_loop_filter #(
    .LOCK_N(LOCK_N), .LOCK_TH(LOCK_TH), .UNLOCK_TH(UNLOCK_TH),
    .ACQ_KP(ACQ_KP), .ACQ_KI(ACQ_KI), .TRK_KP(TRK_KP), .TRK_KI(TRK_KI),
    .RATIO_INIT(RATIO_INIT)
  ) i_filt (
    .clk(clk), .rst_n(rst_n), .pd_valid(pd_valid), .pd_err(pd_err),
    .ev_timeout(ev_timeout), .ratio(ratio_w), .locked(locked), .err_big(err_big)
  );

  asrc_phase_nco i_nco (
    .clk(clk), .rst_n(rst_n), .tick(out_tick), .ratio(ratio_w),
    .phase(phase_frac), .step(phase_step), .valid(phase_valid)
  );

  assign ratio_q = ratio_w;
endmodule

// File: rtl/asrc_ratio_dpll_chk.sv
module asrc_ratio_dpll_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_strobe,
  input logic        out_tick,
  input logic [31:0] ratio_q,
  input logic [23:0] phase_frac,
  input logic        phase_valid,
  input logic        locked,
  input logic        pd_valid,
  input logic        ev_timeout,
  input logic        err_big,
  input logic        starved
);
  a_r6_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    out_tick |=> phase_valid);

  a_r6_phase_advance: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid |-> phase_frac == 24'($past(phase_frac) + $past(ratio_q[23:0])));

  a_r7_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_valid |-> $stable(phase_frac));

  a_r10_ratio_moves_on_measure: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pd_valid) |-> $stable(ratio_q));

  a_r9_timeout_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> !locked);

  a_r4_lock_on_measure: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(pd_valid));

  a_r8_unlock_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(ev_timeout || err_big));

  a_r11_align_no_measure: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strobe && starved) |=> !pd_valid);
endmodule

bind asrc_ratio_dpll asrc_ratio_dpll_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_strobe(in_strobe), .out_tick(out_tick),
  .ratio_q(ratio_q), .phase_frac(phase_frac), .phase_valid(phase_valid),
  .locked(locked), .pd_valid(pd_valid), .ev_timeout(ev_timeout),
  .err_big(err_big), .starved(starved)
);

// File: tb/test_asrc_ratio_dpll.sv
`timescale 1ns/1ps
module test_asrc_ratio_dpll;
  localparam int TO = 600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_strobe = 1'b0;
  logic        out_tick = 1'b0;
  logic [31:0] ratio_q;
  logic [23:0] phase_frac;
  logic [8:0]  phase_step;
  logic        phase_valid;
  logic        locked;

  asrc_ratio_dpll #(.TIMEOUT(TO)) i_asrc_ratio_dpll (
    .clk(clk), .rst_n(rst_n), .in_strobe(in_strobe), .out_tick(out_tick),
    .ratio_q(ratio_q), .phase_frac(phase_frac), .phase_step(phase_step),
    .phase_valid(phase_valid), .locked(locked)
  );

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  longint cyc = 0, nom_q = 0, per_q = 0, ramp_q = 0;
  int ramp_left = 0, jit_amp = 0, jit_cur = 0, inj_cnt = 0, tick_cnt = 0;
  int strobes_sent = 0, step_bad = 0, hold_bad = 0, lock_drops = 0;
  bit gen_en = 0, mon_en = 0, watch_lock = 0, tick_pend = 0;
  logic [23:0] prev_phase = '0;
  logic [31:0] r_at = '0;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic step();
    logic [32:0] sum;
    bit strb;
    @(negedge clk);
    if (mon_en) begin
      if (tick_pend) begin
        sum = {9'b0, prev_phase} + {1'b0, r_at};
        if (!phase_valid || phase_frac != sum[23:0] || phase_step != sum[32:24]) step_bad++;
      end else if (phase_valid || phase_frac != prev_phase) hold_bad++;
      if (watch_lock && !locked) lock_drops++;
    end
    prev_phase = phase_frac;
    out_tick  = (tick_cnt == 0);
    tick_pend = out_tick;
    if (out_tick) r_at = ratio_q;
    tick_cnt = (tick_cnt == 15) ? 0 : tick_cnt + 1;
    strb = 0;
    if (gen_en && ((cyc <<< 16) >= nom_q + (longint'(jit_cur) <<< 16))) begin
      strb = 1;
      strobes_sent++;
      nom_q += per_q;
      if (ramp_left > 0) begin per_q += ramp_q; ramp_left--; end
      jit_cur = (jit_amp > 0) ? int'($urandom_range(2 * jit_amp)) - jit_amp : 0;
    end
    if (inj_cnt > 0 && (cyc % 3) == 0) begin strb = 1; inj_cnt--; end
    in_strobe = strb;
    cyc++;
  endtask

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic run_strobes(int n);
    int target;
    target = strobes_sent + n;
    while (strobes_sent < target) step();
  endtask

  task automatic set_gen(longint per, int jit);
    per_q = per; jit_amp = jit; jit_cur = 0; ramp_left = 0;
    nom_q = (cyc <<< 16) + per;
    gen_en = 1;
  endtask

  task automatic chk_ratio(string req);
    longint expv, diff;
    expv = (longint'(16) <<< 40) / per_q;
    diff = longint'(ratio_q) - expv;
    if (diff < 0) diff = -diff;
    chk(diff <= expv / 50, req, "ratio within 2%", longint'(ratio_q), expv);
  endtask

  task automatic chk_phase(string tag);
    chk(step_bad == 0, "R6", {tag, " phase step mismatches"}, step_bad, 0);
    chk(hold_bad == 0, "R7", {tag, " phase hold violations"}, hold_bad, 0);
    step_bad = 0; hold_bad = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    run_cycles(4);
    chk(ratio_q == 32'h0100_0000, "R1", "reset ratio", ratio_q, 32'h0100_0000);
    chk(phase_frac == 0, "R1", "reset phase", phase_frac, 0);
    chk(phase_valid == 0 && locked == 0, "R1", "reset valid/lock", {phase_valid, locked}, 0);
    rst_n = 1;
    prev_phase = phase_frac;
    tick_pend = 0;
    mon_en = 1;
    run_cycles(3);
  endtask

  task automatic t_first_align();
    inj_cnt = 1;
    run_cycles(12);
    chk(ratio_q == 32'h0100_0000, "R11", "ratio after aligning strobe", ratio_q, 32'h0100_0000);
  endtask

  task automatic t_acq_441();
    set_gen(longint'(16 * 320) * 65536 / 147, 3);
    run_strobes(1000);
    chk(locked == 1, "R4", "locked at 44.1 equivalent", locked, 1);
    chk_ratio("R2");
    chk_phase("44.1");
  endtask

  task automatic t_switch_48();
    set_gen(longint'(32) * 65536, 3);
    run_strobes(1000);
    chk(locked == 1, "R3", "locked at 48 equivalent", locked, 1);
    chk_ratio("R3");
    chk_phase("48");
  endtask

  task automatic t_ramp();
    ramp_q = 131;
    ramp_left = 800;
    lock_drops = 0;
    watch_lock = 1;
    run_strobes(950);
    watch_lock = 0;
    chk(lock_drops == 0, "R5", "cycles unlocked during ramp", lock_drops, 0);
    chk_ratio("R5");
    chk_phase("ramp");
  endtask

  task automatic t_burst();
    inj_cnt = 8;
    run_cycles(40);
    chk(locked == 0, "R8", "lock after strobe burst", locked, 0);
    run_strobes(500);
    chk(locked == 1, "R8", "relock after burst", locked, 1);
    chk_ratio("R8");
  endtask

  task automatic t_timeout();
    logic [31:0] r_hold;
    int s0;
    gen_en = 0;
    run_cycles(10);
    r_hold = ratio_q;
    run_cycles(TO + 20);
    chk(locked == 0, "R9", "lock after silent gap", locked, 0);
    chk(ratio_q == r_hold, "R10", "ratio held over gap", ratio_q, r_hold);
    s0 = strobes_sent;
    set_gen(longint'(32) * 65536, 3);
    while (strobes_sent == s0) step();
    run_cycles(4);
    chk(ratio_q == r_hold, "R11", "ratio after first strobe past timeout", ratio_q, r_hold);
    run_strobes(5);
    chk(locked == 0, "R4", "no lock before LOCK_N strobes", locked, 0);
    run_strobes(500);
    chk(locked == 1, "R4", "relock after gap", locked, 1);
    chk_phase("timeout");
  endtask

  initial begin
    t_reset();
    t_first_align();
    t_acq_441();
    t_switch_48();
    t_ramp();
    t_burst();
    t_timeout();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    tests++;
    fails++;
    $display("FAIL watchdog: actual cycles %0d expected below 200000", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule